// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Logic

This block sits between an in-order decode buffer and two symmetric integer execution pipes. Every cycle it looks at the two oldest decoded instructions and decides whether none, only the older one, or both may leave. It reports that number back to the buffer, which pops that many entries. The issued instructions appear one cycle later in the pipe-0 and pipe-1 issue slots.

The older instruction always lands in pipe 0. Each instruction belongs to an ALU, multiply or load-store class. Multiply and load-store work do not add issue slots; each uses one of the two pipe slots. A multiply may only sit in pipe 0. A load-store may sit in either pipe. The younger instruction stays behind if it depends on a register the older one writes. A busy scoreboard vector holds back any instruction whose source register is still being produced. When the older instruction is held, nothing issues, so the younger one never passes it.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset both pipe slots are empty (`p0_valid` and `p1_valid` low).
- R2: When the oldest entry is not valid, `issue_cnt` is 0 and the pipe slots are empty in the next cycle.
- R3: When `issue_cnt` is 1 or 2, in the next cycle `p0_valid` is high and pipe 0 carries the older instruction's class and tag.
- R4: Two valid, independent ALU-class instructions (class code 0) with no busy sources issue together: `issue_cnt` is 2 and pipe 1 carries the younger instruction's class and tag in the next cycle.
- R5: A multiply (class code 1) never issues in pipe 1. An older multiply may pair with a younger non-multiply.
- R6: A load-store (class code 2) may issue in either pipe, but two load-stores never issue in the same cycle.
- R7: When the older instruction writes a register (`a_wr` high), the younger one does not pair if either of its sources equals `a_dst`, or if it also writes `a_dst`. When `a_wr` is low, `a_dst` creates no dependency.
- R8: When a source register of the older instruction is marked busy in `busy`, `issue_cnt` is 0, even if the younger instruction could issue.
- R9: When only the younger instruction has a busy source, `issue_cnt` is 1.
- R10: `issue_cnt` equals the number of filled pipe slots in the next cycle, and pipe 1 is never filled without pipe 0.
- R11: When the older instruction can issue and the younger entry is not valid, `issue_cnt` is 1. Class code 3 pairs like an ALU instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 2**REG_W | Scoreboard, one bit per register; a set bit means the register is not yet readable |
| a_valid | input | 1 | Older entry present |
| a_class | input | 2 | Older class: 0 ALU, 1 multiply, 2 load-store, 3 treated as ALU |
| a_src0 | input | REG_W | Older first source register |
| a_src1 | input | REG_W | Older second source register |
| a_dst | input | REG_W | Older destination register |
| a_wr | input | 1 | Older instruction writes `a_dst` |
| a_tag | input | TAG_W | Older instruction tag, carried to the pipe |
| b_valid | input | 1 | Younger entry present |
| b_class | input | 2 | Younger class, same coding |
| b_src0 | input | REG_W | Younger first source register |
| b_src1 | input | REG_W | Younger second source register |
| b_dst | input | REG_W | Younger destination register |
| b_wr | input | 1 | Younger instruction writes `b_dst` |
| b_tag | input | TAG_W | Younger instruction tag |
| issue_cnt | output | 2 | Entries consumed this cycle (0, 1 or 2) |
| p0_valid | output | 1 | Pipe-0 slot filled |
| p0_class | output | 2 | Pipe-0 class |
| p0_tag | output | TAG_W | Pipe-0 tag |
| p1_valid | output | 1 | Pipe-1 slot filled |
| p1_class | output | 2 | Pipe-1 class |
| p1_tag | output | TAG_W | Pipe-1 tag |

## Verification
The hardest case to reach is a younger instruction that could pair by class but fails for one reason alone, while the older one is free to go. Examples are a dependency through `a_dst` with `a_wr` low or high, or a busy bit on only the younger source. In random traffic these reasons nearly always come together. Directed pairs therefore change one field at a time against a clean baseline. A long random stream then follows. It draws registers from a narrow range of eight so that dependencies and busy collisions are frequent. It feeds the pair from a program-order queue that is popped by the reported count, so a wrong count shows up as a wrong tag in a later pipe slot.

// File: rtl/dual_issue_pair.sv
module dual_issue_pair #(
  parameter int REG_W = 5,
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<REG_W)-1:0] busy,
  input  logic                  a_valid,
  input  logic [1:0]            a_class,
  input  logic [REG_W-1:0]      a_src0,
  input  logic [REG_W-1:0]      a_src1,
  input  logic [REG_W-1:0]      a_dst,
  input  logic                  a_wr,
  input  logic [TAG_W-1:0]      a_tag,
  input  logic                  b_valid,
  input  logic [1:0]            b_class,
  input  logic [REG_W-1:0]      b_src0,
  input  logic [REG_W-1:0]      b_src1,
  input  logic [REG_W-1:0]      b_dst,
  input  logic                  b_wr,
  input  logic [TAG_W-1:0]      b_tag,
  output logic [1:0]            issue_cnt,
  output logic                  p0_valid,
  output logic [1:0]            p0_class,
  output logic [TAG_W-1:0]      p0_tag,
  output logic                  p1_valid,
  output logic [1:0]            p1_class,
  output logic [TAG_W-1:0]      p1_tag
);
  localparam logic [1:0] CLS_MUL = 2'd1;
  localparam logic [1:0] CLS_LS  = 2'd2;

  logic a_ready, b_ready, hazard, slot_ok, pair;

  assign a_ready = a_valid && !busy[a_src0] && !busy[a_src1];
  assign b_ready = b_valid && !busy[b_src0] && !busy[b_src1];
  assign hazard  = a_wr && ((b_src0 == a_dst) || (b_src1 == a_dst) ||
                            (b_wr && (b_dst == a_dst)));
  assign slot_ok = (b_class != CLS_MUL) &&
                   !((a_class == CLS_LS) && (b_class == CLS_LS));
  assign pair    = a_ready && b_ready && slot_ok && !hazard;

  assign issue_cnt = !a_ready ? 2'd0 : (pair ? 2'd2 : 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0_valid <= 1'b0;
      p0_class <= '0;
      p0_tag   <= '0;
      p1_valid <= 1'b0;
      p1_class <= '0;
      p1_tag   <= '0;
    end else begin
      p0_valid <= a_ready;
      p0_class <= a_class;
      p0_tag   <= a_tag;
      p1_valid <= pair;
      p1_class <= b_class;
      p1_tag   <= b_tag;
    end
  end
endmodule

// File: rtl/dual_issue_pair_chk.sv
module dual_issue_pair_chk #(
  parameter int REG_W = 5,
  parameter int TAG_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [(1<<REG_W)-1:0] busy,
  input logic                  a_valid,
  input logic [1:0]            a_class,
  input logic [REG_W-1:0]      a_src0,
  input logic [REG_W-1:0]      a_src1,
  input logic [TAG_W-1:0]      a_tag,
  input logic [1:0]            issue_cnt,
  input logic                  p0_valid,
  input logic [1:0]            p0_class,
  input logic [TAG_W-1:0]      p0_tag,
  input logic                  p1_valid,
  input logic [1:0]            p1_class
);
  AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> issue_cnt == 2'd0);  // R2
  AST_OLDER_IN_PIPE0: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cnt != 2'd0 |=> p0_valid && p0_tag == $past(a_tag) && p0_class == $past(a_class));  // R3
  AST_NO_MUL_PIPE1: assert property (@(posedge clk) disable iff (!rst_n)
    p1_valid |-> p1_class != 2'd1);  // R5
  AST_SINGLE_LS: assert property (@(posedge clk) disable iff (!rst_n)
    !(p1_valid && p0_class == 2'd2 && p1_class == 2'd2));  // R6
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && (busy[a_src0] || busy[a_src1])) |-> issue_cnt == 2'd0);  // R8
  AST_PIPE1_NEEDS_PIPE0: assert property (@(posedge clk) disable iff (!rst_n)
    p1_valid |-> p0_valid);  // R10
  AST_CNT_MATCHES_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (p0_valid + p1_valid) == $past(issue_cnt));  // R10
endmodule

bind dual_issue_pair dual_issue_pair_chk #(.REG_W(REG_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .a_valid(a_valid), .a_class(a_class),
  .a_src0(a_src0), .a_src1(a_src1), .a_tag(a_tag), .issue_cnt(issue_cnt),
  .p0_valid(p0_valid), .p0_class(p0_class), .p0_tag(p0_tag),
  .p1_valid(p1_valid), .p1_class(p1_class)
);

// File: tb/dual_issue_pair_bench.sv
module dual_issue_pair_bench;
  typedef struct packed {
    logic       v;
    logic [1:0] cls;
    logic [4:0] s0;
    logic [4:0] s1;
    logic [4:0] d;
    logic       w;
    logic [7:0] tag;
  } instr_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [31:0] busy = '0;
  instr_t ia = '0, ib = '0;
  logic [1:0] issue_cnt;
  logic p0_valid, p1_valid;
  logic [1:0] p0_class, p1_class;
  logic [7:0] p0_tag, p1_tag;

  int errors = 0;
  int checks = 0;
  int last_m = 0;
  logic   exp_p0v = 0, exp_p1v = 0;
  instr_t exp_p0 = '0, exp_p1 = '0;

  always #4 clk = ~clk;

  dual_issue_pair u_dual_issue_pair (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .a_valid(ia.v), .a_class(ia.cls), .a_src0(ia.s0), .a_src1(ia.s1),
    .a_dst(ia.d), .a_wr(ia.w), .a_tag(ia.tag),
    .b_valid(ib.v), .b_class(ib.cls), .b_src0(ib.s0), .b_src1(ib.s1),
    .b_dst(ib.d), .b_wr(ib.w), .b_tag(ib.tag),
    .issue_cnt(issue_cnt),
    .p0_valid(p0_valid), .p0_class(p0_class), .p0_tag(p0_tag),
    .p1_valid(p1_valid), .p1_class(p1_class), .p1_tag(p1_tag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, got, want);
    end
  endtask

  function automatic int model_cnt(instr_t a, instr_t b, logic [31:0] bz);
    if (!a.v) return 0;
    if (bz[a.s0] || bz[a.s1]) return 0;
    if (!b.v) return 1;
    if (bz[b.s0] || bz[b.s1]) return 1;
    if (b.cls == 2'd1) return 1;
    if (a.cls == 2'd2 && b.cls == 2'd2) return 1;
    if (a.w && (b.s0 == a.d || b.s1 == a.d || (b.w && b.d == a.d))) return 1;
    return 2;
  endfunction

  function automatic instr_t mk(logic [1:0] c, int s0, int s1, int d, logic w, int t);
    instr_t x;
    x.v = 1; x.cls = c; x.s0 = s0[4:0]; x.s1 = s1[4:0]; x.d = d[4:0]; x.w = w; x.tag = t[7:0];
    return x;
  endfunction

  task automatic check_pipes(input string req);
    check(p0_valid == exp_p0v, req, "p0_valid", p0_valid, exp_p0v);
    check(p1_valid == exp_p1v, "R10", "p1_valid", p1_valid, exp_p1v);
    if (exp_p0v) begin
      check(p0_tag == exp_p0.tag, "R3", "p0_tag", p0_tag, exp_p0.tag);
      check(p0_class == exp_p0.cls, "R3", "p0_class", p0_class, exp_p0.cls);
    end
    if (exp_p1v) begin
      check(p1_tag == exp_p1.tag, "R4", "p1_tag", p1_tag, exp_p1.tag);
      check(p1_class == exp_p1.cls, "R6", "p1_class", p1_class, exp_p1.cls);
    end
  endtask

  task automatic step(input instr_t a, input instr_t b, input logic [31:0] bz,
                      input int want, input string req);
    int m;
    check_pipes(req);
    ia = a; ib = b; busy = bz;
    #1;
    m = model_cnt(a, b, bz);
    if (want >= 0) check(m == want, req, "bench model", m, want);
    check(issue_cnt == m, req, "issue_cnt", issue_cnt, m);
    last_m = m;
    exp_p0v = (m >= 1); exp_p0 = a;
    exp_p1v = (m == 2); exp_p1 = b;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL R1: watchdog expired got 1 expected 0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    instr_t nov;
    instr_t prog[$];
    nov = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(issue_cnt == 0, "R2", "issue_cnt at reset", issue_cnt, 0);
    // R1: reset state, checked inside first step
    step(nov, mk(0,1,2,3,1,9), '0, 0, "R1");
    step(nov, mk(0,1,2,3,1,9), '0, 0, "R2");
    step(mk(0,1,2,3,1,10), mk(0,4,5,6,1,11), '0, 2, "R4");
    step(mk(1,1,2,3,1,12), mk(0,4,5,6,1,13), '0, 2, "R5");
    step(mk(0,1,2,3,1,14), mk(1,4,5,6,1,15), '0, 1, "R5");
    step(mk(1,1,2,3,1,16), mk(1,4,5,6,1,17), '0, 1, "R5");
    step(mk(2,1,2,3,1,18), mk(0,4,5,6,1,19), '0, 2, "R6");
    step(mk(0,1,2,3,1,20), mk(2,4,5,6,1,21), '0, 2, "R6");
    step(mk(2,1,2,3,0,22), mk(2,4,5,6,0,23), '0, 1, "R6");
    step(mk(0,1,2,3,1,24), mk(0,3,5,6,1,25), '0, 1, "R7");
    step(mk(0,1,2,3,1,26), mk(0,4,3,6,1,27), '0, 1, "R7");
    step(mk(0,1,2,3,1,28), mk(0,4,5,3,1,29), '0, 1, "R7");
    step(mk(0,1,2,3,0,30), mk(0,3,5,3,1,31), '0, 2, "R7");
    step(mk(0,1,2,3,1,32), mk(0,4,5,6,1,33), 32'h4, 0, "R8");
    step(mk(0,1,2,3,1,34), mk(0,4,5,6,1,35), 32'h20, 1, "R9");
    step(mk(0,1,2,3,1,36), nov, '0, 1, "R11");
    step(mk(3,1,2,3,1,37), mk(3,4,5,6,1,38), '0, 2, "R11");
    // random program-order stream
    for (int i = 0; i < 600; i++) begin
      instr_t x;
      x.v = 1; x.cls = 2'($urandom % 4);
      x.s0 = 5'($urandom % 8); x.s1 = 5'($urandom % 8); x.d = 5'($urandom % 8);
      x.w = 1'($urandom % 4 != 0); x.tag = 8'(i + 64);
      prog.push_back(x);
    end
    while (prog.size() > 0) begin
      instr_t a, b;
      logic [31:0] bz;
      a = prog[0];
      b = (prog.size() > 1) ? prog[1] : nov;
      bz = ($urandom % 3 == 0) ? (32'h1 << ($urandom % 8)) : 32'h0;
      step(a, b, bz, -1, "R3");
      for (int k = 0; k < last_m; k++) void'(prog.pop_front());
    end
    step(nov, nov, '0, 0, "R2");
    check_pipes("R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule